// File: doc/BRIEF.md
# Multi-Lane Byte Striper and Merger

This block spreads a packetised byte stream over one to four parallel byte lanes on the transmit side and rebuilds the single ordered stream on the receive side. The transmit half collects incoming bytes into a word that is one byte wide per lane. It releases the word on all lanes in the same cycle once the word is full, or early when the packet ends. The lane count is a build-time parameter and cannot change at run time. Each lane carries its own valid and end-of-transmission flags. When a packet length is not a multiple of the lane count, the higher lanes run out one byte sooner than the lower ones.

The receive half takes one byte port per lane, with valid and end-of-transmission flags, and queues each lane separately. The lanes may therefore arrive skewed against one another by a few cycles. A merge pointer walks the lanes round-robin from lane 0. It emits one byte per cycle in the original order and waits whenever the lane it needs next has nothing queued. Packet start and end markers are regenerated on the merged stream.

Top module: `lane_stripe_link`

## Requirements
- R1: Byte k of a packet, counted from the byte flagged start-of-packet, leaves on lane k mod N in bits [8*lane+7 : 8*lane] of the lane data vector. All bytes of one word appear together, in the cycle after the input byte that fills the word or ends the packet.
- R2: In the final word of a packet of length L with r = L mod N nonzero, only lanes 0 to r-1 are valid. The lane valid mask is always a contiguous run starting at lane 0.
- R3: End-of-transmission is raised on all N lanes together, for one cycle, in the cycle of a packet's final word and in no other cycle.
- R4: The merged output carries every received byte exactly once and in the original order. Start-of-packet is flagged on a packet's first byte and end-of-packet on its last byte.
- R5: When the next expected lane has no byte queued, the merger emits nothing and waits. Lane skew within the per-lane queue depth never loses data, and a queue is never written while full.
- R6: On the receive side, end-of-transmission with valid marks a lane's last byte, and end-of-transmission without valid marks a lane that finished early. Such an empty mark is consumed without output, and the next packet resumes at lane 0.
- R7: While and right after reset, no lane is valid, no end-of-transmission flag is raised and the merged output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is first of its packet |
| in_eop | input | 1 | Input byte is last of its packet |
| tx_valid | output | LANES | Per-lane byte valid |
| tx_data | output | 8*LANES | Per-lane bytes, lane l in bits [8l+7:8l] |
| tx_eot | output | LANES | Per-lane end-of-transmission |
| rx_valid | input | LANES | Received per-lane byte valid |
| rx_data | input | 8*LANES | Received per-lane bytes |
| rx_eot | input | LANES | Received per-lane end-of-transmission |
| out_valid | output | 1 | Merged byte valid |
| out_data | output | 8 | Merged byte |
| out_sop | output | 1 | Merged byte is first of packet |
| out_eop | output | 1 | Merged byte is last of packet |

## Verification
The bench goes after packets of one byte up to a few bytes, where fewer bytes than lanes exist. A striper that got this wrong would raise valid on empty lanes or leave lanes without their end flag. A merger that got it wrong would hang on a lane that never delivers, or fail to return to lane 0. Random lengths of up to 64 bytes with every remainder are run for each lane count from 1 to 4. The lanes are deliberately skewed on the way back, so a merger that does not wait for the lagging lane would reorder or duplicate bytes. Start and end markers are compared byte by byte, which catches an end flag placed on a lower lane's last byte instead of the packet's last byte.

// File: rtl/lane_stripe_pkg.sv
package lane_stripe_pkg;
    localparam int MAX_LANES  = 4;
    localparam int LANE_IDX_W = 2;

    typedef logic [7:0]            byte_t;
    typedef logic [LANE_IDX_W-1:0] lane_idx_t;

    // One queued lane entry: a byte, or an empty end mark.
    typedef struct packed {
        logic  empty_mark;
        logic  last_byte;
        byte_t data;
    } lane_ent_t;

    function automatic lane_idx_t next_lane(lane_idx_t cur, int lanes);
        return (int'(cur) == lanes - 1) ? lane_idx_t'(0) : lane_idx_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/lane_queue.sv
module lane_queue
    import lane_stripe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  lane_ent_t wr_ent,
    input  logic      pop,
    output lane_ent_t rd_ent,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    lane_ent_t          mem [DEPTH];
    logic [PTR_W-1:0]   wr_q, rd_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_ent  = mem[rd_q];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= wr_ent;
                wr_q      <= bump(wr_q);
            end
            if (do_pop) rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/lane_striper.sv
module lane_striper
    import lane_stripe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  byte_t              in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    output logic [LANES-1:0]   tx_valid,
    output logic [LANES*8-1:0] tx_data,
    output logic [LANES-1:0]   tx_eot
);
    localparam int LAST = LANES - 1;

    lane_idx_t idx_q, cur;
    byte_t     hold_q [MAX_LANES];
    logic      emit;

    always_comb begin
        cur  = in_sop ? lane_idx_t'(0) : idx_q;
        emit = in_valid && (in_eop || int'(cur) == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            tx_valid <= '0;
            tx_eot   <= '0;
            tx_data  <= '0;
            for (int i = 0; i < MAX_LANES; i++) hold_q[i] <= '0;
        end else begin
            tx_valid <= '0;
            tx_eot   <= '0;
            if (in_valid) begin
                hold_q[cur] <= in_data;
                idx_q       <= emit ? lane_idx_t'(0) : cur + 1'b1;
            end
            if (emit) begin
                for (int l = 0; l < LANES; l++) begin
                    tx_data[l*8 +: 8] <= (l == int'(cur)) ? in_data : hold_q[l];
                    tx_valid[l]       <= (l <= int'(cur));
                end
                tx_eot <= in_eop ? '1 : '0;
            end
        end
    end
endmodule

// File: rtl/lane_merger.sv
module lane_merger
    import lane_stripe_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   rx_valid,
    input  logic [LANES*8-1:0] rx_data,
    input  logic [LANES-1:0]   rx_eot,
    output logic               out_valid,
    output byte_t              out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [LANES-1:0]   q_push,
    output logic [LANES-1:0]   q_full
);
    localparam int LAST = LANES - 1;

    lane_ent_t               head [MAX_LANES];
    logic [MAX_LANES-1:0]    empty, pop_v;
    lane_idx_t               ptr_q, nx;
    logic                    fire, eop, adv, in_pkt_q;

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_q
        if (l < LANES) begin : g_on
            lane_ent_t ent;
            assign q_push[l]      = rx_valid[l] | rx_eot[l];
            assign ent.empty_mark = rx_eot[l] & ~rx_valid[l];
            assign ent.last_byte  = rx_eot[l] & rx_valid[l];
            assign ent.data       = rx_data[l*8 +: 8];
            lane_queue #(.DEPTH(FIFO_DEPTH)) u_q (
                .clk    (clk),
                .rst    (rst),
                .push   (q_push[l]),
                .wr_ent (ent),
                .pop    (pop_v[l]),
                .rd_ent (head[l]),
                .empty  (empty[l]),
                .full   (q_full[l])
            );
        end else begin : g_off
            assign head[l]  = '0;
            assign empty[l] = 1'b1;
        end
    end

    always_comb begin
        nx    = next_lane(ptr_q, LANES);
        fire  = 1'b0;
        eop   = 1'b0;
        adv   = 1'b0;
        pop_v = '0;
        if (!empty[ptr_q]) begin
            if (head[ptr_q].empty_mark) begin
                adv = 1'b1;
            end else if (!head[ptr_q].last_byte || int'(ptr_q) == LAST) begin
                fire = 1'b1;
                eop  = head[ptr_q].last_byte;
            end else if (!empty[nx]) begin
                // a lane's last byte ends the packet only if the next lane is done
                fire = 1'b1;
                eop  = head[nx].empty_mark;
            end
            if (fire) adv = 1'b1;
            pop_v[ptr_q] = adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            in_pkt_q  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= fire;
            if (adv) ptr_q <= nx;
            if (fire) begin
                out_data <= head[ptr_q].data;
                out_sop  <= !in_pkt_q;
                out_eop  <= eop;
                in_pkt_q <= !eop;
            end
        end
    end
endmodule

// File: rtl/lane_stripe_link.sv
module lane_stripe_link
    import lane_stripe_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    input  logic               in_sop,
    input  logic               in_eop,
    output logic [LANES-1:0]   tx_valid,
    output logic [LANES*8-1:0] tx_data,
    output logic [LANES-1:0]   tx_eot,
    input  logic [LANES-1:0]   rx_valid,
    input  logic [LANES*8-1:0] rx_data,
    input  logic [LANES-1:0]   rx_eot,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_sop,
    output logic               out_eop
);
    logic [LANES-1:0] rx_push, rx_full;

    lane_striper #(.LANES(LANES)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_eot   (tx_eot)
    );

    lane_merger #(.LANES(LANES), .FIFO_DEPTH(FIFO_DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eot    (rx_eot),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .q_push    (rx_push),
        .q_full    (rx_full)
    );
endmodule

// File: rtl/lane_stripe_chk.sv
module lane_stripe_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_eop,
    input logic [LANES-1:0] tx_valid,
    input logic [LANES-1:0] tx_eot,
    input logic             out_valid,
    input logic [LANES-1:0] q_push,
    input logic [LANES-1:0] q_full
);
    logic             started_q;
    logic [LANES:0]   vmask;

    assign vmask = {1'b0, tx_valid};

    always_ff @(posedge clk) started_q <= 1'b1;

    // R1: a packet end on the input shows up on the lanes one cycle later
    p_eop_to_lanes_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_eop |=> tx_eot[0]);

    // R2: valid lanes form a run from lane 0
    p_valid_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        (vmask & (vmask + 1'b1)) == '0);

    // R3: end-of-transmission on all lanes or none
    p_eot_all_r3: assert property (@(posedge clk) disable iff (rst)
        (|tx_eot) |-> (&tx_eot));

    // R5: no lane queue written while full
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (q_push & q_full) == '0);

    // R7: quiet outputs right after reset
    p_reset_quiet_r7: assert property (@(posedge clk)
        started_q && $past(rst) |-> (tx_valid == '0) && (tx_eot == '0) && !out_valid);
endmodule

bind lane_stripe_link lane_stripe_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .tx_valid  (tx_valid),
    .tx_eot    (tx_eot),
    .out_valid (out_valid),
    .q_push    (rx_push),
    .q_full    (rx_full)
);

// File: tb/lane_stripe_link_tb_top.sv
`timescale 1ns/1ps
module lane_stripe_link_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = '0;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    logic [7:0] sent_data  [$];
    bit         sent_first [$];
    bit         sent_last  [$];

    always #2.5 clk = ~clk;

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    for (genvar gn = 1; gn <= 4; gn++) begin : g_n
        logic [gn-1:0]   txv, txe, rxv, rxe;
        logic [gn*8-1:0] txd, rxd;
        logic            ov, os, oe;
        logic [7:0]      od;
        int              rd = 0, tg = 0, cnt;

        lane_stripe_link #(.LANES(gn), .FIFO_DEPTH(8)) dut_i (
            .clk (clk), .rst (rst),
            .in_valid (in_valid), .in_data (in_data), .in_sop (in_sop), .in_eop (in_eop),
            .tx_valid (txv), .tx_data (txd), .tx_eot (txe),
            .rx_valid (rxv), .rx_data (rxd), .rx_eot (rxe),
            .out_valid (ov), .out_data (od), .out_sop (os), .out_eop (oe)
        );

        // skewed loopback: each lane gets its own delay of 0..3 cycles (R5)
        for (genvar gl = 0; gl < gn; gl++) begin : g_l
            localparam int D = (gl * 3 + gn) % 4;
            logic [9:0] pipe [4];
            logic [9:0] now, sel;
            assign now = {txv[gl], txe[gl], txd[gl*8 +: 8]};
            always_ff @(posedge clk) begin
                if (rst) for (int s = 0; s < 4; s++) pipe[s] <= '0;
                else begin
                    pipe[0] <= now;
                    for (int s = 1; s < 4; s++) pipe[s] <= pipe[s-1];
                end
            end
            assign sel = (D == 0) ? now : pipe[(D == 0) ? 0 : D - 1];
            assign rxv[gl] = sel[9];
            assign rxe[gl] = sel[8];
            assign rxd[gl*8 +: 8] = sel[7:0];
        end

        always @(negedge clk) if (!rst) begin
            // R4 / R5 / R6: merged stream equals the input stream
            if (ov) begin
                chk(rd < sent_data.size(), "R4", "extra merged byte", rd, sent_data.size());
                if (rd < sent_data.size()) begin
                    chk(od == sent_data[rd], "R4", "merged byte", od, sent_data[rd]);
                    chk(os == sent_first[rd], "R4", "merged sop", os, sent_first[rd]);
                    chk(oe == sent_last[rd], "R6", "merged eop", oe, sent_last[rd]);
                end
                rd++;
            end
            // R1 / R2 / R3: lane word contents
            if ((|txv) || (|txe)) begin
                cnt = 0;
                while (cnt < gn && tg + cnt < sent_data.size()) begin
                    cnt++;
                    if (sent_last[tg + cnt - 1]) break;
                end
                for (int l = 0; l < gn; l++) begin
                    chk(txv[l] == (l < cnt), "R2", "lane valid", txv[l], l < cnt);
                    if (l < cnt)
                        chk(txd[l*8 +: 8] == sent_data[tg + l], "R1", "lane byte",
                            txd[l*8 +: 8], sent_data[tg + l]);
                end
                if (cnt > 0)
                    chk((txe != '0) == sent_last[tg + cnt - 1], "R3", "eot placement",
                        txe != '0, sent_last[tg + cnt - 1]);
                if (txe != '0) chk(&txe, "R3", "eot on all lanes", txe, (1 << gn) - 1);
                tg += cnt;
            end
        end
    end

    task automatic send_pkt(int len, bit gaps);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1;
            in_data  = 8'($urandom);
            in_sop   = (k == 0);
            in_eop   = (k == len - 1);
            sent_data.push_back(in_data);
            sent_first.push_back(k == 0);
            sent_last.push_back(k == len - 1);
            @(posedge clk); #1;
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
                @(posedge clk); #1;
            end
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (12) @(posedge clk);
        #1;
    endtask

    function automatic void quiet(string n, logic anyv, logic anye, logic o);
        chk(!anyv && !anye && !o, "R7", {"reset quiet ", n}, {anyv, anye, o}, 0);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        quiet("n1", |g_n[1].txv, |g_n[1].txe, g_n[1].ov);
        quiet("n2", |g_n[2].txv, |g_n[2].txe, g_n[2].ov);
        quiet("n3", |g_n[3].txv, |g_n[3].txe, g_n[3].ov);
        quiet("n4", |g_n[4].txv, |g_n[4].txe, g_n[4].ov);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        quiet("n4 post", |g_n[4].txv, |g_n[4].txe, g_n[4].ov);
        @(posedge clk); #1;
        // directed: lengths below, at and just above the lane counts (R2, R6)
        for (int len = 1; len <= 9; len++) send_pkt(len, 1'b0);
        send_pkt(64, 1'b0);
        // random lengths 1..64 with occasional input gaps
        for (int p = 0; p < 60; p++) send_pkt(1 + ($urandom % 64), 1'b1);
        repeat (60) @(posedge clk);
        @(negedge clk);
        // R4: lossless for every lane count
        chk(g_n[1].rd == sent_data.size(), "R4", "n1 merged count", g_n[1].rd, sent_data.size());
        chk(g_n[2].rd == sent_data.size(), "R4", "n2 merged count", g_n[2].rd, sent_data.size());
        chk(g_n[3].rd == sent_data.size(), "R4", "n3 merged count", g_n[3].rd, sent_data.size());
        chk(g_n[4].rd == sent_data.size(), "R4", "n4 merged count", g_n[4].rd, sent_data.size());
        chk(g_n[4].tg == sent_data.size(), "R1", "n4 striped count", g_n[4].tg, sent_data.size());
        chk(g_n[3].tg == sent_data.size(), "R1", "n3 striped count", g_n[3].tg, sent_data.size());
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule